// File: doc/BRIEF.md
# Interlocked Four-Phase Handshake Bus

This block links one bus master to a row of memory slaves over dedicated address, status, write-data and read-data lines. No fixed cycle count governs a transfer. Every edge on the request side waits for the matching edge on the acknowledge side, and the reverse also holds. Slaves that take very different times to answer can therefore share the same wires. The master and each slave are synchronous state machines. Each one passes the other side's handshake lines through a two-flop synchronizer before it acts on them.

The user side of the master takes a one-cycle `start` pulse carrying direction, address and write data. It raises `busy` for the whole transfer and pulses `done` when the transfer completes, with the read result on `rdata`. The top address bits pick a slave. Each slave holds a small word memory and waits a number of cycles before it answers. That delay grows with the slave's index: `BASE_LAT + index * LAT_STEP`. The bus lines are brought out as outputs so the sequence can be observed.

Top module: `hsb_bus_top`

## Requirements
- R1: After reset, `busy`, `done`, `bus_addr_vld`, `bus_status`, `bus_rd`, `bus_wr`, `bus_ack` and `bus_rdata_vld` are all 0.
- R2: An accepted start drives `bus_addr`, `bus_addr_vld`=1 and `bus_status` (1 = write) at the same edge. The command (`bus_rd` for reads, `bus_wr` for writes) rises one cycle later. The address stays unchanged while `bus_addr_vld` is 1.
- R3: For a read, the selected slave drives `bus_rdata` with `bus_rdata_vld`=1 at least one cycle before it raises `bus_ack`. It keeps driving until ack falls. `rdata` carries that word in the cycle `done` is 1.
- R4: For a write, `bus_wdata` is driven together with the address, before `bus_wr` rises. It stays stable while `bus_wr` is 1. The slave stores the word, and a later read of that address returns it.
- R5: Interlock. The command falls only while `bus_ack` is 1. `bus_ack` falls only after the command is 0. `bus_addr_vld` falls only when both ack and command are 0.
- R6: The slave index is the top `SEL_W` address bits. `bus_ack` rises exactly `BASE_LAT + index*LAT_STEP + 5` cycles after the command rises.
- R7: A `start` pulse is ignored while `busy` is 1. It changes no memory word and starts no transfer.
- R8: At most one slave acknowledges at a time. A write to one slave leaves every word of the other slaves unchanged.
- R9: `done` is 1 for exactly the cycle in which `bus_addr_vld` falls, and `busy` is 0 from then on.
- R10: A new transfer begins, with `bus_addr_vld` rising, only while `bus_ack` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a transfer |
| start_write | input | 1 | 1 = write, 0 = read |
| start_addr | input | AW | Transfer address |
| start_wdata | input | DW | Word to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Word returned by the last read |
| bus_addr | output | AW | Address lines |
| bus_addr_vld | output | 1 | Address and status are driven |
| bus_status | output | 1 | Direction status line, 1 = write |
| bus_rd | output | 1 | Read command |
| bus_wr | output | 1 | Write command |
| bus_wdata | output | DW | Master data lines |
| bus_rdata | output | DW | Slave data lines (OR of all slaves) |
| bus_rdata_vld | output | 1 | Some slave is driving read data |
| bus_ack | output | 1 | Acknowledge (OR of all slaves) |

## Verification
A slave state machine stuck in its hold state keeps `bus_ack` high. The master never finishes, and the missing `done` shows up within a few dozen cycles. A wrong latency counter moves the ack edge by whole cycles, so the exact command-to-ack delay measured for both the fast and the slow slave reveals it on the first transfer. A misdecoded address or a bad memory write shows up at the ports as a wrong read word in the sweep. It also shows up as a changed word in the slave that was not written.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

  typedef enum logic [1:0] {M_IDLE, M_SET, M_WACK, M_WREL} mst_state_e;
  typedef enum logic [1:0] {S_IDLE, S_WORK, S_DSET, S_HOLD} slv_state_e;

  // response delay of slave number idx
  function automatic int slave_lat(input int idx, input int base, input int step);
    return base + idx * step;
  endfunction

  // width of a down-counter able to hold n
  function automatic int cnt_width(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/hsb_sync2.sv
module hsb_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hsb_master.sv
module hsb_master
  import hsb_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_write,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] m_addr,
  output logic          m_addr_vld,
  output logic          m_status,
  output logic          m_rd,
  output logic          m_wr,
  output logic [DW-1:0] m_wdata,
  input  logic          s_ack,
  input  logic [DW-1:0] s_rdata
);
  mst_state_e st;
  logic       ack_s;

  hsb_sync2 #(.W(1)) u_ack_sync (.clk(clk), .rst_n(rst_n), .d(s_ack), .q(ack_s));

  assign busy = (st != M_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= M_IDLE;
      m_addr     <= '0;
      m_addr_vld <= 1'b0;
      m_status   <= 1'b0;
      m_rd       <= 1'b0;
      m_wr       <= 1'b0;
      m_wdata    <= '0;
      done       <= 1'b0;
      rdata      <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        M_IDLE: if (start && !ack_s) begin
          m_addr     <= start_addr;
          m_addr_vld <= 1'b1;
          m_status   <= start_write;
          m_wdata    <= start_write ? start_wdata : '0;
          st         <= M_SET;
        end
        M_SET: begin
          m_rd <= !m_status;
          m_wr <= m_status;
          st   <= M_WACK;
        end
        M_WACK: if (ack_s) begin
          if (!m_status) rdata <= s_rdata;
          m_rd <= 1'b0;
          m_wr <= 1'b0;
          st   <= M_WREL;
        end
        M_WREL: if (!ack_s) begin
          m_addr_vld <= 1'b0;
          m_addr     <= '0;
          m_status   <= 1'b0;
          m_wdata    <= '0;
          done       <= 1'b1;
          st         <= M_IDLE;
        end
        default: st <= M_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hsb_slave.sv
module hsb_slave
  import hsb_pkg::*;
#(
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int SEL_W = 1,
  parameter int IDX   = 0,
  parameter int LAT   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] m_addr,
  input  logic          m_addr_vld,
  input  logic          m_rd,
  input  logic          m_wr,
  input  logic [DW-1:0] m_wdata,
  output logic          s_ack,
  output logic          s_drv,
  output logic [DW-1:0] s_rdata
);
  localparam int LAW = AW - SEL_W;
  localparam int DEPTH = 1 << LAW;
  localparam int CW = cnt_width(LAT);
  localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(IDX);

  slv_state_e     st;
  logic [1:0]     cmd_s;
  logic [CW-1:0]  cnt;
  logic           op_wr;
  logic [DW-1:0]  dout;
  logic [DW-1:0]  mem [DEPTH];
  logic           hit;
  logic           mem_we;
  logic [LAW-1:0] loc;

  hsb_sync2 #(.W(2)) u_cmd_sync (.clk(clk), .rst_n(rst_n), .d({m_wr, m_rd}), .q(cmd_s));

  assign hit    = m_addr_vld && (m_addr[AW-1 -: SEL_W] == MY_SEL);
  assign loc    = m_addr[LAW-1:0];
  assign mem_we = (st == S_WORK) && (cnt == '0) && op_wr;

  always_ff @(posedge clk) begin
    if (mem_we) mem[loc] <= m_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      op_wr <= 1'b0;
      dout  <= '0;
      s_drv <= 1'b0;
      s_ack <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if ((|cmd_s) && hit) begin
          cnt   <= CW'(LAT);
          op_wr <= cmd_s[1];
          st    <= S_WORK;
        end
        S_WORK: if (cnt == '0) begin
          if (!op_wr) begin
            dout  <= mem[loc];
            s_drv <= 1'b1;
          end
          st <= S_DSET;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_DSET: begin
          s_ack <= 1'b1;
          st    <= S_HOLD;
        end
        S_HOLD: if (!(|cmd_s)) begin
          s_ack <= 1'b0;
          s_drv <= 1'b0;
          dout  <= '0;
          st    <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign s_rdata = s_drv ? dout : '0;
endmodule

// File: rtl/hsb_bus_top.sv
module hsb_bus_top
  import hsb_pkg::*;
#(
  parameter int AW       = 4,
  parameter int DW       = 8,
  parameter int SEL_W    = 1,
  parameter int BASE_LAT = 1,
  parameter int LAT_STEP = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_write,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] bus_addr,
  output logic          bus_addr_vld,
  output logic          bus_status,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rdata_vld,
  output logic          bus_ack
);
  localparam int N_SLV = 1 << SEL_W;

  logic [N_SLV-1:0] slv_ack;
  logic [N_SLV-1:0] slv_drv;
  logic [DW-1:0]    slv_rdata [N_SLV];

  hsb_master #(.AW(AW), .DW(DW)) u_master (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_write(start_write), .start_addr(start_addr), .start_wdata(start_wdata),
    .busy(busy), .done(done), .rdata(rdata),
    .m_addr(bus_addr), .m_addr_vld(bus_addr_vld), .m_status(bus_status),
    .m_rd(bus_rd), .m_wr(bus_wr), .m_wdata(bus_wdata),
    .s_ack(bus_ack), .s_rdata(bus_rdata)
  );

  for (genvar g = 0; g < N_SLV; g++) begin : g_slv
    hsb_slave #(
      .AW(AW), .DW(DW), .SEL_W(SEL_W), .IDX(g),
      .LAT(slave_lat(g, BASE_LAT, LAT_STEP))
    ) u_slave (
      .clk(clk), .rst_n(rst_n),
      .m_addr(bus_addr), .m_addr_vld(bus_addr_vld),
      .m_rd(bus_rd), .m_wr(bus_wr), .m_wdata(bus_wdata),
      .s_ack(slv_ack[g]), .s_drv(slv_drv[g]), .s_rdata(slv_rdata[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < N_SLV; i++) bus_rdata = bus_rdata | slv_rdata[i];
  end

  assign bus_ack       = |slv_ack;
  assign bus_rdata_vld = |slv_drv;
endmodule

// File: rtl/hsb_checker.sv
module hsb_checker #(
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int N_SLV = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic             busy,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_addr_vld,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic [DW-1:0]    bus_wdata,
  input logic             bus_rdata_vld,
  input logic             bus_ack,
  input logic [N_SLV-1:0] slv_ack
);
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_vld && $past(bus_addr_vld)) |-> $stable(bus_addr));
  // R2
  cmd_needs_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_rd) || $rose(bus_wr)) |-> (bus_addr_vld && $past(bus_addr_vld)));
  // R3
  data_before_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_ack) && bus_rd) |-> $past(bus_rdata_vld));
  // R3
  data_while_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack && bus_rd) |-> bus_rdata_vld);
  // R4
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && $past(bus_wr)) |-> $stable(bus_wdata));
  // R5
  cmd_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_rd) || $fell(bus_wr)) |-> bus_ack);
  // R5
  ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ack) |-> (!bus_rd && !bus_wr));
  // R5
  addr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_addr_vld) |-> (!bus_ack && !bus_rd && !bus_wr));
  // R8
  one_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slv_ack));
  // R8
  no_dual_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  // R9
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($fell(bus_addr_vld) && !busy));
  // R10
  start_ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_addr_vld) |-> !bus_ack);
endmodule

bind hsb_bus_top hsb_checker #(.AW(AW), .DW(DW), .N_SLV(N_SLV)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .busy(busy),
  .bus_addr(bus_addr), .bus_addr_vld(bus_addr_vld),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .bus_rdata_vld(bus_rdata_vld), .bus_ack(bus_ack), .slv_ack(slv_ack)
);

// File: tb/tb_hsb_bus_top.sv
module tb_hsb_bus_top;
  localparam int AW = 4, DW = 8, SEL_W = 1, BASE_LAT = 1, LAT_STEP = 6;
  localparam int NW = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, start_write = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [DW-1:0] start_wdata = '0;
  logic busy, done, bus_addr_vld, bus_status, bus_rd, bus_wr, bus_rdata_vld, bus_ack;
  logic [DW-1:0] rdata, bus_wdata, bus_rdata;
  logic [AW-1:0] bus_addr;

  int checks = 0, fails = 0, cyc = 0;
  logic [DW-1:0] model [NW];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hsb_bus_top #(.AW(AW), .DW(DW), .SEL_W(SEL_W), .BASE_LAT(BASE_LAT), .LAT_STEP(LAT_STEP)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_write(start_write),
    .start_addr(start_addr), .start_wdata(start_wdata), .busy(busy), .done(done),
    .rdata(rdata), .bus_addr(bus_addr), .bus_addr_vld(bus_addr_vld), .bus_status(bus_status),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdata_vld(bus_rdata_vld), .bus_ack(bus_ack)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int exp_ack_delay(input logic [AW-1:0] a);
    int idx = int'(a >> (AW - SEL_W));
    return BASE_LAT + idx * LAT_STEP + 5;
  endfunction

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'((a * 37 + 5 + k * 91) % 256);
  endfunction

  // protocol monitor
  logic p_cmd = 0, p_ack = 0, p_avld = 0, p_dvld = 0, p_wr = 0;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_wd = '0;
  int t_cmd = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if ((bus_rd || bus_wr) && !p_cmd) begin
        t_cmd = cyc;
        chk(bus_addr_vld && p_avld, "R2 addr before cmd", int'(p_avld), 1);
        if (bus_wr) chk(p_wr && bus_wdata == p_wd, "R4 wdata before wr", int'(bus_wdata), int'(p_wd));
      end
      if (bus_ack && !p_ack) begin
        chk(cyc - t_cmd == exp_ack_delay(bus_addr), "R6 ack delay", cyc - t_cmd, exp_ack_delay(bus_addr));
        if (bus_rd) chk(p_dvld, "R3 data before ack", int'(p_dvld), 1);
      end
      if (p_avld && bus_addr_vld)
        chk(bus_addr == p_addr, "R2 addr held", int'(bus_addr), int'(p_addr));
      if (p_cmd && !(bus_rd || bus_wr)) chk(bus_ack, "R5 cmd fall needs ack", int'(bus_ack), 1);
      if (p_ack && !bus_ack) chk(!bus_rd && !bus_wr, "R5 ack fall after cmd", int'(bus_rd | bus_wr), 0);
      if (bus_addr_vld && !p_avld) chk(!bus_ack, "R10 start with ack low", int'(bus_ack), 0);
      if (p_avld && !bus_addr_vld) chk(done && !busy, "R9 done at release", int'(done), 1);
      p_cmd = bus_rd || bus_wr; p_ack = bus_ack; p_avld = bus_addr_vld;
      p_dvld = bus_rdata_vld; p_addr = bus_addr; p_wr = bus_status; p_wd = bus_wdata;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  task automatic pulse(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    start = 1'b1; start_write = w; start_addr = a; start_wdata = d;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output logic ok);
    ok = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    chk(ok, "R9 transfer completes", int'(ok), 1);
  endtask

  task automatic xfer(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic ok;
    pulse(w, a, d);
    chk(busy && bus_addr_vld && bus_status == w, "R2 address phase", int'(bus_status), int'(w));
    wait_done(ok);
    if (w) model[a] = d;
    else chk(rdata == model[a], "R3 read data", int'(rdata), int'(model[a]));
    @(negedge clk);
  endtask

  initial begin
    logic ok;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !bus_addr_vld && !bus_status, "R1 reset master", int'(busy), 0);
    chk(!bus_rd && !bus_wr && !bus_ack && !bus_rdata_vld, "R1 reset bus", int'(bus_ack), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 fill every address on both slaves
    for (int a = 0; a < NW; a++) xfer(1'b1, AW'(a), pat(a, 0));
    // R3 read back
    for (int a = 0; a < NW; a++) xfer(1'b0, AW'(a), '0);
    // R8 overwrite slave 0 only, then read everything
    for (int a = 0; a < NW / 2; a++) xfer(1'b1, AW'(a), pat(a, 1));
    for (int a = 0; a < NW; a++) xfer(1'b0, AW'(a), '0);
    // R7 start during a busy transfer is ignored
    pulse(1'b1, AW'(3), 8'h5A);
    repeat (3) @(negedge clk);
    pulse(1'b1, AW'(12), 8'hEE);
    wait_done(ok);
    model[3] = 8'h5A;
    @(negedge clk);
    chk(!busy && !bus_addr_vld, "R7 no extra transfer", int'(busy), 0);
    @(negedge clk);
    chk(!busy, "R7 still idle", int'(busy), 0);
    xfer(1'b0, AW'(12), '0);
    xfer(1'b0, AW'(3), '0);
    // back-to-back fast/slow reads
    xfer(1'b0, AW'(15), '0);
    xfer(1'b0, AW'(0), '0);
    finish_run();
  end
endmodule